// File: doc/BRIEF.md
# Stepper Drive Current Configurator with Readback Check

This block sets the phase current of a stepper drive over an SPI link and confirms every change by reading the same register back. The drive has two operating current levels. A low level holds the motor while it is idle, and a high level is used while motion is commanded. When the one-bit motion command changes, the block sends a write frame that carries the matching level. It then sends a query frame for the same register and a third frame that collects the returned byte. The returned byte is compared with the byte that was written.

If the two bytes differ, the block raises a safe-mode output and holds it until reset. External logic uses this output to cut motor power and close the fluid clamps. After that the block issues no further SPI traffic. A busy output covers the whole write, query and collect sequence. Command changes that arrive during a sequence are not lost. When the sequence finishes, the block compares the present command with the level it last wrote and starts again if they differ.

The register address, the two current values, the SCLK divider and the minimum chip-select gap are all parameters.

Top module: `curcfg_top`

## Requirements
- R1: After reset, `csN` is high, `sclk` is low, `busy` is 0 and `safeMode` is 0. The applied level starts as idle, so no frame is sent while `moveCmd` stays 0.
- R2: A change of `moveCmd` from 0 to 1 sends a write frame whose data byte is `RUN_VAL`. A change from 1 to 0 sends a write frame whose data byte is `IDLE_VAL`. A frame is 1+`ADDR_W`+`DATA_W` bits, sent MSB first. Bit 15 is the access bit (0 = write, 1 = read), bits 14:8 hold `REG_ADDR` and bits 7:0 hold the data.
- R3: Every write frame is followed by two read frames. Each read frame has the access bit at 1, the address `REG_ADDR` and a data field of 0x00. During the second read frame, the drive returns the register value on `miso` in bits 7:0, and that byte is the one compared with the written byte.
- R4: SPI mode 0 is used. `sclk` is low whenever `csN` is high. `mosi` changes only while `sclk` is low. Each frame has exactly 16 rising `sclk` edges.
- R5: Each high phase and each low phase of `sclk` inside a frame lasts exactly `CLK_DIV` clock cycles.
- R6: Between two frames, `csN` stays high for at least 2*`GAP_SCLK`*`CLK_DIV` clock cycles.
- R7: `busy` rises on the clock edge after a command change is seen. It stays high throughout the write, query and collect frames, so it is high whenever `csN` is low.
- R8: When the collected byte equals the written byte, `safeMode` stays 0 and `busy` returns to 0.
- R9: When the collected byte differs from the written byte, `safeMode` becomes 1 and stays 1. After that, `busy` stays 0 and no frame is sent, even if `moveCmd` changes.
- R10: A command change during a sequence is handled once the sequence finishes. A new sequence starts only if `moveCmd` then differs from the last written level. A command that toggles away and back during a sequence causes no extra frames.
- R11: Reset clears `safeMode` and returns the applied level to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| moveCmd | input | 1 | Motion command: 1 = moving (full current), 0 = idle (low current) |
| miso | input | 1 | Serial data from the drive |
| sclk | output | 1 | SPI serial clock, idle low |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the drive |
| busy | output | 1 | A write/query/collect sequence is in progress |
| safeMode | output | 1 | Latched readback-mismatch indication |

## Verification
The command is driven with single rising and falling changes, which separate the two written data bytes and show that a sequence always has three frames. A second change made while a sequence is running must produce a later sequence with the new level. A glitch that returns to the written level before the sequence ends must produce no extra frames, which separates queueing by level from queueing by event. The drive model then corrupts its returned byte, which separates the mismatch path from the match path. Further command changes after that must leave the link silent, and a reset must clear the latch.

// File: rtl/curcfg_pkg.sv
package curcfg_pkg;

  // Kind of frame the sequencer asks the datapath to send
  typedef enum logic [1:0] {
    FK_WRITE   = 2'd0,
    FK_QUERY   = 2'd1,
    FK_COLLECT = 2'd2
  } frameKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       start;
    frameKind_t kind;
    logic       runLevel;
  } seqCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic frameDone;
    logic readMatch;
  } dpStat_t;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_WRITE   = 3'd1,
    SQ_QUERY   = 3'd2,
    SQ_COLLECT = 3'd3,
    SQ_SAFE    = 3'd4
  } seqState_t;

endpackage

// File: rtl/curcfg_spi_dp.sv
module curcfg_spi_dp
  import curcfg_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 4,
  parameter int unsigned GAP_SCLK = 2,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 7'h0B,
  parameter logic [DATA_W-1:0] IDLE_VAL = 8'h08,
  parameter logic [DATA_W-1:0] RUN_VAL  = 8'h1F
) (
  input  logic    clk,
  input  logic    rst_n,
  input  seqCtl_t ctl,
  input  logic    miso,
  output dpStat_t stat,
  output logic    sclk,
  output logic    csN,
  output logic    mosi
);

  localparam int unsigned FRAME_W   = 1 + ADDR_W + DATA_W;
  localparam int unsigned BIT_W     = $clog2(FRAME_W);
  localparam int unsigned DIV_W     = $clog2(CLK_DIV) + 1;
  localparam int unsigned GAP_TICKS = 2 * GAP_SCLK;
  localparam int unsigned GAP_W     = $clog2(GAP_TICKS) + 1;

  typedef enum logic [1:0] {DP_IDLE, DP_SHIFT, DP_GAP} dpState_t;

  dpState_t            dpState;
  logic [DIV_W-1:0]    divCnt;
  logic [BIT_W-1:0]    bitCnt;
  logic [GAP_W-1:0]    gapCnt;
  logic [FRAME_W-1:0]  txShift;
  logic [FRAME_W-1:0]  txWord;
  logic [DATA_W-1:0]   rxShift;
  logic [DATA_W-1:0]   expVal;
  logic                sclkR;
  logic                csNR;
  logic                doneR;
  logic                tick;

  // Half-period tick; a divider of one needs no counter compare
  generate
    if (CLK_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      assign tick = (divCnt == DIV_W'(CLK_DIV - 1));
    end
  endgenerate

  // Frame composition: access bit, address, data
  always_comb begin
    if (ctl.kind == FK_WRITE) begin
      txWord = {1'b0, REG_ADDR, (ctl.runLevel ? RUN_VAL : IDLE_VAL)};
    end else begin
      txWord = {1'b1, REG_ADDR, {DATA_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpState <= DP_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      gapCnt  <= '0;
      txShift <= '0;
      rxShift <= '0;
      expVal  <= '0;
      sclkR   <= 1'b0;
      csNR    <= 1'b1;
      doneR   <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (dpState)
        DP_IDLE: begin
          divCnt <= '0;
          if (ctl.start) begin
            txShift <= txWord;
            csNR    <= 1'b0;
            sclkR   <= 1'b0;
            bitCnt  <= '0;
            dpState <= DP_SHIFT;
            if (ctl.kind == FK_WRITE) begin
              expVal <= txWord[DATA_W-1:0];
            end
          end
        end
        DP_SHIFT: begin
          divCnt <= tick ? '0 : divCnt + 1'b1;
          if (tick) begin
            if (!sclkR) begin
              sclkR   <= 1'b1;
              rxShift <= {rxShift[DATA_W-2:0], miso};
            end else begin
              sclkR <= 1'b0;
              if (bitCnt == BIT_W'(FRAME_W - 1)) begin
                csNR    <= 1'b1;
                gapCnt  <= '0;
                dpState <= DP_GAP;
              end else begin
                txShift <= {txShift[FRAME_W-2:0], 1'b0};
                bitCnt  <= bitCnt + 1'b1;
              end
            end
          end
        end
        DP_GAP: begin
          divCnt <= tick ? '0 : divCnt + 1'b1;
          if (tick) begin
            if (gapCnt == GAP_W'(GAP_TICKS - 1)) begin
              dpState <= DP_IDLE;
              doneR   <= 1'b1;
            end else begin
              gapCnt <= gapCnt + 1'b1;
            end
          end
        end
        default: dpState <= DP_IDLE;
      endcase
    end
  end

  assign stat.frameDone = doneR;
  assign stat.readMatch = (rxShift == expVal);
  assign sclk = sclkR;
  assign csN  = csNR;
  assign mosi = ~csNR & txShift[FRAME_W-1];

endmodule

// File: rtl/curcfg_seq.sv
module curcfg_seq
  import curcfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    moveCmd,
  input  dpStat_t stat,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    safeMode
);

  seqState_t state;
  logic      appliedLvl;
  logic      safeR;
  logic      cmdChanged;

  assign cmdChanged = (moveCmd != appliedLvl);

  always_comb begin
    ctl          = '0;
    ctl.kind     = FK_WRITE;
    ctl.runLevel = appliedLvl;
    case (state)
      SQ_IDLE: begin
        if (cmdChanged) begin
          ctl.start    = 1'b1;
          ctl.kind     = FK_WRITE;
          ctl.runLevel = moveCmd;
        end
      end
      SQ_WRITE: begin
        if (stat.frameDone) begin
          ctl.start = 1'b1;
          ctl.kind  = FK_QUERY;
        end
      end
      SQ_QUERY: begin
        if (stat.frameDone) begin
          ctl.start = 1'b1;
          ctl.kind  = FK_COLLECT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      appliedLvl <= 1'b0;
      safeR      <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (cmdChanged) begin
            appliedLvl <= moveCmd;
            state      <= SQ_WRITE;
          end
        end
        SQ_WRITE:   if (stat.frameDone) state <= SQ_QUERY;
        SQ_QUERY:   if (stat.frameDone) state <= SQ_COLLECT;
        SQ_COLLECT: begin
          if (stat.frameDone) begin
            if (stat.readMatch) begin
              state <= SQ_IDLE;
            end else begin
              safeR <= 1'b1;
              state <= SQ_SAFE;
            end
          end
        end
        SQ_SAFE: state <= SQ_SAFE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy     = (state == SQ_WRITE) || (state == SQ_QUERY) || (state == SQ_COLLECT);
  assign safeMode = safeR;

endmodule

// File: rtl/curcfg_top.sv
module curcfg_top
  import curcfg_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 4,
  parameter int unsigned GAP_SCLK = 2,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 7'h0B,
  parameter logic [DATA_W-1:0] IDLE_VAL = 8'h08,
  parameter logic [DATA_W-1:0] RUN_VAL  = 8'h1F
) (
  input  logic clk,
  input  logic rst_n,
  input  logic moveCmd,
  input  logic miso,
  output logic sclk,
  output logic csN,
  output logic mosi,
  output logic busy,
  output logic safeMode
);

  seqCtl_t seqCtl;
  dpStat_t dpStat;

  curcfg_seq seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .moveCmd  (moveCmd),
    .stat     (dpStat),
    .ctl      (seqCtl),
    .busy     (busy),
    .safeMode (safeMode)
  );

  curcfg_spi_dp #(
    .CLK_DIV  (CLK_DIV),
    .GAP_SCLK (GAP_SCLK),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR),
    .IDLE_VAL (IDLE_VAL),
    .RUN_VAL  (RUN_VAL)
  ) dp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (seqCtl),
    .miso  (miso),
    .stat  (dpStat),
    .sclk  (sclk),
    .csN   (csN),
    .mosi  (mosi)
  );

endmodule

// File: rtl/curcfg_chk.sv
module curcfg_chk #(
  parameter int unsigned CLK_DIV  = 4,
  parameter int unsigned GAP_SCLK = 2,
  parameter int unsigned FRAME_W  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic csN,
  input logic mosi,
  input logic busy,
  input logic safeMode
);

  logic [15:0] hiCnt;
  logic [31:0] csHighCnt;
  logic [7:0]  riseCnt;
  logic        sclkQ;
  logic        seenFrame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiCnt     <= '0;
      csHighCnt <= '0;
      riseCnt   <= '0;
      sclkQ     <= 1'b0;
      seenFrame <= 1'b0;
    end else begin
      sclkQ <= sclk;
      hiCnt <= sclk ? hiCnt + 1'b1 : '0;
      if (csN) begin
        if (csHighCnt != '1) csHighCnt <= csHighCnt + 1'b1;
        riseCnt <= '0;
      end else begin
        csHighCnt <= '0;
        seenFrame <= 1'b1;
        if (sclk && !sclkQ) riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !sclk);

  a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sclk) && sclk) |-> $stable(mosi));

  a_r4_frame_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csN) |-> (riseCnt == 8'(FRAME_W)));

  a_r5_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hiCnt == 16'(CLK_DIV)));

  a_r6_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(csN) && seenFrame) |-> (csHighCnt >= 32'(2 * GAP_SCLK * CLK_DIV)));

  a_r7_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !csN |-> busy);

  a_r9_safe_latched: assert property (@(posedge clk) disable iff (!rst_n)
    safeMode |=> safeMode);

  a_r9_safe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    safeMode |-> (csN && !busy));

endmodule

bind curcfg_top curcfg_chk #(
  .CLK_DIV  (CLK_DIV),
  .GAP_SCLK (GAP_SCLK),
  .FRAME_W  (1 + ADDR_W + DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (sclk),
  .csN      (csN),
  .mosi     (mosi),
  .busy     (busy),
  .safeMode (safeMode)
);

// File: tb/curcfg_tb.sv
module curcfg_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 3;
  localparam int GAP_SCLK   = 2;
  localparam logic [6:0] REG_ADDR = 7'h2A;
  localparam logic [7:0] IDLE_VAL = 8'h0C;
  localparam logic [7:0] RUN_VAL  = 8'hF3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic moveCmd = 1'b0;
  logic miso;
  logic sclk, csN, mosi, busy, safeMode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // drive model state
  logic [15:0] expQ[$];
  logic [15:0] rxW = '0;
  logic [15:0] outWord = '0;
  logic [7:0]  drvReg = '0;
  logic [7:0]  corrupt = '0;
  int idx = 0;
  int rises = 0;
  int riseMark = 0;
  int frames = 0;
  logic prevCs = 1'b1;
  logic prevSclk = 1'b0;
  int hiLen = 0, minHi = 1000000, maxHi = 0;
  int gapLen = 0, minGap = 1000000;
  bit seenOne = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso = (!csN && idx < 16) ? outWord[15 - idx] : 1'b0;

  curcfg_top #(
    .CLK_DIV  (CLK_DIV),
    .GAP_SCLK (GAP_SCLK),
    .REG_ADDR (REG_ADDR),
    .IDLE_VAL (IDLE_VAL),
    .RUN_VAL  (RUN_VAL)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .moveCmd  (moveCmd),
    .miso     (miso),
    .sclk     (sclk),
    .csN      (csN),
    .mosi     (mosi),
    .busy     (busy),
    .safeMode (safeMode)
  );

  task automatic chkEq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard: one full sequence for a level
  task automatic expectSeq(input logic lvl);
    expQ.push_back({1'b0, REG_ADDR, (lvl ? RUN_VAL : IDLE_VAL)});
    expQ.push_back({1'b1, REG_ADDR, 8'h00});
    expQ.push_back({1'b1, REG_ADDR, 8'h00});
  endtask

  task automatic frameEnd();
    logic [15:0] e;
    frames++;
    chkEq(32'(rises - riseMark), 32'd16, "R4 rising edges per frame");
    riseMark = rises;
    if (expQ.size() == 0) begin
      chkEq(32'(rxW), 32'hFFFF_FFFF, "R10 unexpected frame");
    end else begin
      e = expQ.pop_front();
      chkEq(32'(rxW), 32'(e), "R2/R3 frame word");
    end
    if (!rxW[15]) drvReg = rxW[7:0];
    outWord = rxW[15] ? {8'h00, drvReg ^ corrupt} : 16'h0000;
  endtask

  // monitor: SPI drive model, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      prevCs = 1'b1; prevSclk = 1'b0; idx = 0; hiLen = 0; gapLen = 0;
    end else begin
      if (prevCs && !csN) begin
        idx = 0;
        if (seenOne && gapLen < minGap) minGap = gapLen;
      end
      if (!csN && sclk && !prevSclk) begin
        rxW = {rxW[14:0], mosi};
        rises++;
      end
      if (!csN && !sclk && prevSclk) idx++;
      if (!prevCs && csN) begin
        seenOne = 1'b1;
        frameEnd();
      end
      if (sclk) hiLen++;
      else if (prevSclk) begin
        if (hiLen < minHi) minHi = hiLen;
        if (hiLen > maxHi) maxHi = hiLen;
        hiLen = 0;
      end
      if (csN) gapLen++; else gapLen = 0;
      prevCs = csN;
      prevSclk = sclk;
    end
  end

  task automatic waitQuiet();
    int quiet = 0;
    for (int n = 0; n < 20000 && quiet < 40; n++) begin
      @(negedge clk);
      if (busy || !csN) quiet = 0; else quiet++;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkEq(32'(csN), 1, "R1 csN after reset");
    chkEq(32'(sclk), 0, "R1 sclk after reset");
    chkEq(32'(busy), 0, "R1 busy after reset");
    chkEq(32'(safeMode), 0, "R1 safeMode after reset");
    repeat (200) @(negedge clk);
    chkEq(32'(frames), 0, "R1 no frame while idle");

    // R2 and R7: idle to moving
    expectSeq(1'b1);
    moveCmd = 1'b1;
    @(negedge clk); @(negedge clk);
    chkEq(32'(busy), 1, "R7 busy after change");
    waitQuiet();
    chkEq(32'(expQ.size()), 0, "R3 all three frames sent");
    chkEq(32'(drvReg), 32'(RUN_VAL), "R2 run level written");
    chkEq(32'(safeMode), 0, "R8 match keeps safeMode low");
    chkEq(32'(busy), 0, "R8 busy released");

    // R2: moving to idle
    expectSeq(1'b0);
    moveCmd = 1'b0;
    waitQuiet();
    chkEq(32'(expQ.size()), 0, "R3 idle sequence complete");
    chkEq(32'(drvReg), 32'(IDLE_VAL), "R2 idle level written");

    // R10: change during a sequence is queued
    expectSeq(1'b1);
    expectSeq(1'b0);
    moveCmd = 1'b1;
    repeat (50) @(negedge clk);
    moveCmd = 1'b0;
    waitQuiet();
    chkEq(32'(expQ.size()), 0, "R10 queued change handled");
    chkEq(32'(drvReg), 32'(IDLE_VAL), "R10 final level idle");

    // R10: glitch back to the written level adds no frames
    f0 = frames;
    expectSeq(1'b1);
    moveCmd = 1'b1;
    repeat (20) @(negedge clk);
    moveCmd = 1'b0;
    repeat (20) @(negedge clk);
    moveCmd = 1'b1;
    waitQuiet();
    chkEq(32'(frames - f0), 3, "R10 glitch coalesced");
    chkEq(32'(expQ.size()), 0, "R10 no pending frames");

    // R5 and R6 timing seen so far
    chkEq(32'(minHi), 32'(CLK_DIV), "R5 min sclk high width");
    chkEq(32'(maxHi), 32'(CLK_DIV), "R5 max sclk high width");
    chkEq(32'(minGap >= 2 * GAP_SCLK * CLK_DIV), 1, "R6 chip-select gap");

    // R9: readback mismatch
    corrupt = 8'h01;
    expectSeq(1'b0);
    moveCmd = 1'b0;
    waitQuiet();
    chkEq(32'(safeMode), 1, "R9 mismatch sets safeMode");
    chkEq(32'(expQ.size()), 0, "R9 sequence frames before halt");
    f0 = frames;
    moveCmd = 1'b1;
    repeat (400) @(negedge clk);
    chkEq(32'(safeMode), 1, "R9 safeMode held");
    chkEq(32'(busy), 0, "R9 busy low in safe mode");
    chkEq(32'(frames - f0), 0, "R9 no frames in safe mode");

    // R11: reset clears latch and applied level
    rst_n = 1'b0;
    corrupt = 8'h00;
    repeat (3) @(negedge clk);
    chkEq(32'(safeMode), 0, "R11 reset clears safeMode");
    expectSeq(1'b1);
    rst_n = 1'b1;
    waitQuiet();
    chkEq(32'(expQ.size()), 0, "R11 sequence after reset");
    chkEq(32'(safeMode), 0, "R11 safeMode low after good readback");
    chkEq(32'(drvReg), 32'(RUN_VAL), "R11 run level rewritten");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule